// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Flags

This block is the arithmetic and logic unit of the execute stage of a small 32-bit processor, together with the register that holds its condition flags. The decode stage gives it two register operands, an unsigned immediate, a select that chooses the immediate in place of the second register, and a 5-bit operation class. In the same cycle it returns the value to write back and a write-enable. At the clock edge that ends the cycle it updates carry, zero, overflow and negative, as far as the operation calls for.

Besides addition, subtraction and the bitwise operations, the unit builds wide constants one byte lane at a time. A lane load puts the immediate into its own lane, keeps the lanes below it from the first operand, and clears every lane above it. A program that loads the lanes from the lowest to the highest therefore assembles a full word. Compare operations change only the flags, so a branch or skip stage that follows can test them. The register file, memory access and branch resolution lie outside this block.

Top module: `alu_flag_unit`

## Requirements
- R1: Class 0 gives R + B and class 2 gives R - B. The result is written (wr_en high) and all four flags are updated.
- R2: Class 1 gives R + B + C and class 3 gives R - B - C, where C is the carry flag stored before the operation.
- R3: After add-type operations the carry flag holds the carry out of bit 31. After subtract-type operations (classes 2, 3, 16, 18) it holds the borrow. The overflow flag holds two's-complement signed overflow.
- R4: After every operation that updates flags from its result, zero is set when the 32-bit result is all zeros and negative copies result bit 31. Logic, shift and rotate classes update only zero and negative and keep carry and overflow.
- R5: Class 4 gives AND, 5 gives OR, 6 gives XOR, 7 gives the bitwise complement of R, and 18 gives 0 - R with full flag update.
- R6: When imm_sel is high, the second operand B is the 8-bit immediate zero-extended, so it is always unsigned. Otherwise B is src_a.
- R7: Classes 8 to 11 load lane k = class - 8 (bits 8k+7:8k) with the immediate, keep the lanes below k from R and clear the lanes above k.
- R8: Class 16 computes R - B and updates all four flags without writing (wr_en low). Class 17 sets zero to R == B, keeps the other flags and does not write.
- R9: Class 14 shifts R left logically and class 15 shifts R right arithmetically. The amount is B[4:0], and an amount of zero leaves R unchanged.
- R10: Class 12 rotates R left and class 13 rotates R right, by B[4:0].
- R11: Lane loads and class 19 (move, result = B) leave all flags unchanged. Classes 20 to 31 neither write nor change flags. Whenever wr_en is low, result is zero.
- R12: With op_valid low, wr_en is low, result is zero and the flags do not change.
- R13: A low rst_n at a rising clock edge clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_class | input | 5 | Operation class |
| imm_sel | input | 1 | Use the immediate as second operand |
| src_r | input | 32 | First register operand R |
| src_a | input | 32 | Second register operand |
| imm | input | 8 | Unsigned immediate |
| result | output | 32 | Write-back value |
| wr_en | output | 1 | Write-back enable |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed-overflow flag |
| flag_n | output | 1 | Negative flag |

## Verification
The bench builds the unit with the default 32-bit data width and 8-bit immediate, which gives four byte lanes and a 5-bit shift amount. With these values the signed-overflow boundaries at 0x7FFFFFFF and 0x80000000 can be driven directly. Shift amounts of 31 and 32 exercise the masking of the amount to its low five bits. Each of the four lane loads can be chained to assemble a whole word.

// File: rtl/alu_pkg.sv
// Package: shared types of the execute-stage ALU.
// Assumes the operation class is 5 bits and the flag order {c,z,v,n}.
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBB   = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOT   = 5'd7,
        OP_LANE0 = 5'd8,
        OP_LANE1 = 5'd9,
        OP_LANE2 = 5'd10,
        OP_LANE3 = 5'd11,
        OP_ROL   = 5'd12,
        OP_ROR   = 5'd13,
        OP_SHL   = 5'd14,
        OP_SAR   = 5'd15,
        OP_CMP   = 5'd16,
        OP_CMPEQ = 5'd17,
        OP_NEG   = 5'd18,
        OP_MOV   = 5'd19
    } alu_op_e;

    // Low two bits of classes 12..15 select the shifter variant.
    typedef enum logic [1:0] {
        SH_ROT_LEFT    = 2'd0,
        SH_ROT_RIGHT   = 2'd1,
        SH_LEFT        = 2'd2,
        SH_ARITH_RIGHT = 2'd3
    } shift_kind_e;

    // Which flags an operation touches.
    typedef enum logic [1:0] {
        FX_NONE  = 2'd0,
        FX_ZN    = 2'd1,
        FX_ZONLY = 2'd2,
        FX_ALL   = 2'd3
    } flag_fx_e;

    typedef struct packed {
        logic c;
        logic z;
        logic v;
        logic n;
    } flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Module: adder/subtractor with carry-in and status outputs.
// For subtraction, cin is a borrow-in and cout is a borrow-out.
// Assumes W >= 2.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         c_in_eff;
    logic         c_raw;
    logic [W:0]   wide_ref;

    // One carry chain: subtraction is a + ~b + not(borrow).
    always_comb begin
        b_eff    = sub ? ~b : b;
        c_in_eff = sub ? ~cin : cin;
        {c_raw, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_in_eff};
        cout     = sub ? ~c_raw : c_raw;
        ovf      = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    // Reference: sign-extended sum, one bit wider, to cross-check overflow.
    always_comb begin
        if (sub)
            wide_ref = {a[W-1], a} - {b[W-1], b} - {{W{1'b0}}, cin};
        else
            wide_ref = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, cin};
        AST_OVF_MATCHES_WIDE: assert (ovf == (wide_ref[W] != wide_ref[W-1])) else $error("overflow mismatch"); // R3
        AST_SUM_MATCHES_WIDE: assert (sum == wide_ref[W-1:0]) else $error("sum mismatch"); // R1
    end

endmodule

// File: rtl/alu_shifter.sv
// Module: logical left shift, arithmetic right shift and both rotates.
// Assumes amt already holds only the low log2(W) bits of the operand.
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  res
);
    logic [2*W-1:0] dbl_l;
    logic [2*W-1:0] dbl_r;

    // Rotates take a window of the value placed next to itself.
    always_comb begin
        dbl_l = {a, a} << amt;
        dbl_r = {a, a} >> amt;
        case (kind)
            SH_ROT_LEFT:    res = dbl_l[2*W-1:W];
            SH_ROT_RIGHT:   res = dbl_r[W-1:0];
            SH_LEFT:        res = a << amt;
            default:        res = W'($signed(a) >>> amt);
        endcase
    end

endmodule

// File: rtl/alu_bytelane.sv
// Module: lane-wise immediate load used to assemble wide constants.
// Lanes below sel keep a, lane sel takes imm, lanes above are cleared.
// Assumes W is a multiple of LW and there are at least two lanes.
module alu_bytelane #(
    parameter int W  = 32,
    parameter int LW = 8,
    localparam int NL  = W / LW,
    localparam int LSW = $clog2(NL)
) (
    input  logic [W-1:0]   a,
    input  logic [LW-1:0]  imm,
    input  logic [LSW-1:0] sel,
    output logic [W-1:0]   res
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        // Pick this lane's source by its position relative to sel.
        always_comb begin
            if (LSW'(g) < sel)
                res[g*LW +: LW] = a[g*LW +: LW];
            else if (LSW'(g) == sel)
                res[g*LW +: LW] = imm;
            else
                res[g*LW +: LW] = '0;
        end
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: execute-stage ALU plus carry/zero/overflow/negative register.
// Result and wr_en are combinational in the issue cycle; flags update
// at the closing clock edge. Assumes DATA_W = 4 * IMM_W so that lane
// classes 8..11 map onto the four lanes through op_class[1:0].
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_class,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] src_r,
    input  logic [DATA_W-1:0] src_a,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_n
);
    localparam int SHAMT_W    = $clog2(DATA_W);
    localparam int LANES      = DATA_W / IMM_W;
    localparam int LANE_SEL_W = $clog2(LANES);

    alu_op_e            op;
    logic [DATA_W-1:0]  operand_b;
    logic [DATA_W-1:0]  add_a;
    logic               is_sub;
    logic               carry_in;
    logic [DATA_W-1:0]  sum;
    logic               sum_c;
    logic               sum_v;
    logic [DATA_W-1:0]  shift_res;
    logic [DATA_W-1:0]  lane_res;
    logic [DATA_W-1:0]  res_raw;
    logic               writes;
    flag_fx_e           fx;
    logic               eq_ab;
    flags_t             flags_q;

    assign op = alu_op_e'(op_class);

    // Operand selection: immediate is zero-extended, negate uses 0 - R.
    always_comb begin
        operand_b = imm_sel ? {{(DATA_W-IMM_W){1'b0}}, imm} : src_a;
        add_a     = (op == OP_NEG) ? '0 : src_r;
        is_sub    = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) || (op == OP_NEG);
        carry_in  = ((op == OP_ADC) || (op == OP_SBB)) ? flags_q.c : 1'b0;
        eq_ab     = (src_r == operand_b);
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a    (add_a),
        .b    ((op == OP_NEG) ? src_r : operand_b),
        .sub  (is_sub),
        .cin  (carry_in),
        .sum  (sum),
        .cout (sum_c),
        .ovf  (sum_v)
    );

    alu_shifter #(.W(DATA_W)) u_shifter (
        .a    (src_r),
        .amt  (operand_b[SHAMT_W-1:0]),
        .kind (shift_kind_e'(op_class[1:0])),
        .res  (shift_res)
    );

    alu_bytelane #(.W(DATA_W), .LW(IMM_W)) u_bytelane (
        .a    (src_r),
        .imm  (imm),
        .sel  (op_class[LANE_SEL_W-1:0]),
        .res  (lane_res)
    );

    // Decode: pick the raw result, whether it is written, which flags move.
    always_comb begin
        res_raw = '0;
        writes  = 1'b0;
        fx      = FX_NONE;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: begin
                res_raw = sum;
                writes  = 1'b1;
                fx      = FX_ALL;
            end
            OP_AND: begin res_raw = src_r & operand_b; writes = 1'b1; fx = FX_ZN; end
            OP_OR:  begin res_raw = src_r | operand_b; writes = 1'b1; fx = FX_ZN; end
            OP_XOR: begin res_raw = src_r ^ operand_b; writes = 1'b1; fx = FX_ZN; end
            OP_NOT: begin res_raw = ~src_r;            writes = 1'b1; fx = FX_ZN; end
            OP_LANE0, OP_LANE1, OP_LANE2, OP_LANE3: begin
                res_raw = lane_res;
                writes  = 1'b1;
            end
            OP_ROL, OP_ROR, OP_SHL, OP_SAR: begin
                res_raw = shift_res;
                writes  = 1'b1;
                fx      = FX_ZN;
            end
            OP_CMP:   begin res_raw = sum; fx = FX_ALL; end
            OP_CMPEQ: fx = FX_ZONLY;
            OP_MOV:   begin res_raw = operand_b; writes = 1'b1; end
            default:  ;
        endcase
    end

    // Write-back gating: nothing leaves the unit unless it is written.
    always_comb begin
        wr_en  = op_valid && writes;
        result = wr_en ? res_raw : '0;
    end

    // Flag register: synchronous clear, per-class partial update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (op_valid) begin
            case (fx)
                FX_ALL: begin
                    flags_q.c <= sum_c;
                    flags_q.v <= sum_v;
                    flags_q.z <= (res_raw == '0);
                    flags_q.n <= res_raw[DATA_W-1];
                end
                FX_ZN: begin
                    flags_q.z <= (res_raw == '0);
                    flags_q.n <= res_raw[DATA_W-1];
                end
                FX_ZONLY: flags_q.z <= eq_ab;
                default:  ;
            endcase
        end
    end

    assign flag_c = flags_q.c;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_n = flags_q.n;

    AST_ZERO_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wr_en && (op_class <= 5'd7 || (op_class >= 5'd12 && op_class <= 5'd15) || op_class == 5'd18))
        |=> (flag_z == ($past(result) == '0))); // R4
    AST_NEG_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wr_en && (op_class <= 5'd7 || (op_class >= 5'd12 && op_class <= 5'd15) || op_class == 5'd18))
        |=> (flag_n == $past(result[DATA_W-1]))); // R4
    AST_LOAD_MOVE_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_class >= 5'd8 && op_class <= 5'd11) || op_class >= 5'd19))
        |=> $stable({flag_c, flag_z, flag_v, flag_n})); // R11
    AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_class == 5'd16 || op_class == 5'd17)) |-> !wr_en); // R8
    AST_LANE0_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 5'd8) |-> (result[DATA_W-1:IMM_W] == '0)); // R7
    AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({flag_c, flag_z, flag_v, flag_n})); // R12
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!wr_en && result == '0)); // R12

endmodule

// File: tb/alu_flag_unit_test.sv
// Bench: walks a vector table through the unit, then directed corner tests.
module alu_flag_unit_test;

    typedef struct packed {
        logic [4:0]  op;
        logic        isel;
        logic [31:0] a;
        logic [31:0] b;
        logic [7:0]  imm;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;   // {c,z,v,n} after the operation
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [0:NV-1] = '{
        {5'd0,  1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h00, 32'h00000000, 1'b1, 4'b1100},
        {5'd1,  1'b0, 32'h00000005, 32'h00000006, 8'h00, 32'h0000000C, 1'b1, 4'b0000},
        {5'd0,  1'b0, 32'h7FFFFFFF, 32'h00000001, 8'h00, 32'h80000000, 1'b1, 4'b0011},
        {5'd2,  1'b0, 32'h00000003, 32'h00000005, 8'h00, 32'hFFFFFFFE, 1'b1, 4'b1001},
        {5'd3,  1'b0, 32'h0000000A, 32'h00000003, 8'h00, 32'h00000006, 1'b1, 4'b0000},
        {5'd2,  1'b0, 32'h80000000, 32'h00000001, 8'h00, 32'h7FFFFFFF, 1'b1, 4'b0010},
        {5'd4,  1'b0, 32'hF0F0F0F0, 32'h0F0F0F0F, 8'h00, 32'h00000000, 1'b1, 4'b0110},
        {5'd5,  1'b0, 32'hF0000000, 32'h0000000F, 8'h00, 32'hF000000F, 1'b1, 4'b0011},
        {5'd6,  1'b0, 32'hFFFF0000, 32'hFF00FF00, 8'h00, 32'h00FFFF00, 1'b1, 4'b0010},
        {5'd7,  1'b0, 32'h0000FFFF, 32'h00000000, 8'h00, 32'hFFFF0000, 1'b1, 4'b0011},
        {5'd18, 1'b0, 32'h00000001, 32'h00000000, 8'h00, 32'hFFFFFFFF, 1'b1, 4'b1001},
        {5'd18, 1'b0, 32'h00000000, 32'h00000000, 8'h00, 32'h00000000, 1'b1, 4'b0100},
        {5'd0,  1'b1, 32'h00000010, 32'hDEADBEEF, 8'hFF, 32'h0000010F, 1'b1, 4'b0000},
        {5'd2,  1'b1, 32'h00000100, 32'h00000000, 8'h80, 32'h00000080, 1'b1, 4'b0000},
        {5'd16, 1'b1, 32'h00000042, 32'h00000000, 8'h42, 32'h00000000, 1'b0, 4'b0100},
        {5'd16, 1'b0, 32'h00000001, 32'h00000002, 8'h00, 32'h00000000, 1'b0, 4'b1001},
        {5'd17, 1'b0, 32'h00000007, 32'h00000007, 8'h00, 32'h00000000, 1'b0, 4'b1101},
        {5'd17, 1'b0, 32'h00000007, 32'h00000008, 8'h00, 32'h00000000, 1'b0, 4'b1001},
        {5'd8,  1'b0, 32'h12345678, 32'h00000000, 8'hAB, 32'h000000AB, 1'b1, 4'b1001},
        {5'd9,  1'b0, 32'h000000AB, 32'h00000000, 8'hCD, 32'h0000CDAB, 1'b1, 4'b1001},
        {5'd10, 1'b0, 32'hFFFFCDAB, 32'h00000000, 8'hEF, 32'h00EFCDAB, 1'b1, 4'b1001},
        {5'd11, 1'b0, 32'h00EFCDAB, 32'h00000000, 8'h01, 32'h01EFCDAB, 1'b1, 4'b1001},
        {5'd19, 1'b0, 32'h00000000, 32'hDEADBEEF, 8'h00, 32'hDEADBEEF, 1'b1, 4'b1001},
        {5'd14, 1'b0, 32'h00000001, 32'h0000001F, 8'h00, 32'h80000000, 1'b1, 4'b1001},
        {5'd14, 1'b0, 32'h12345678, 32'h00000020, 8'h00, 32'h12345678, 1'b1, 4'b1000},
        {5'd15, 1'b0, 32'h80000000, 32'h00000004, 8'h00, 32'hF8000000, 1'b1, 4'b1001},
        {5'd15, 1'b1, 32'h40000000, 32'h00000000, 8'h0F, 32'h00008000, 1'b1, 4'b1000},
        {5'd14, 1'b1, 32'h0000000F, 32'h00000000, 8'h04, 32'h000000F0, 1'b1, 4'b1000},
        {5'd12, 1'b0, 32'h80000001, 32'h00000001, 8'h00, 32'h00000003, 1'b1, 4'b1000},
        {5'd13, 1'b0, 32'h80000001, 32'h00000001, 8'h00, 32'hC0000000, 1'b1, 4'b1001},
        {5'd12, 1'b0, 32'h12345678, 32'h00000024, 8'h00, 32'h23456781, 1'b1, 4'b1000},
        {5'd13, 1'b0, 32'hAAAA5555, 32'h00000000, 8'h00, 32'hAAAA5555, 1'b1, 4'b1001},
        {5'd31, 1'b0, 32'h00000001, 32'h00000001, 8'h00, 32'h00000000, 1'b0, 4'b1001}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [4:0]  op_class;
    logic        imm_sel;
    logic [31:0] src_r;
    logic [31:0] src_a;
    logic [7:0]  imm;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_c, flag_z, flag_v, flag_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    alu_flag_unit #(.DATA_W(32), .IMM_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .imm_sel(imm_sel), .src_r(src_r), .src_a(src_a), .imm(imm),
        .result(result), .wr_en(wr_en),
        .flag_c(flag_c), .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
    );

    // Requirement tag for a table row: result check or flag check.
    function automatic string tag_of(input logic [4:0] op, input logic isel, input logic for_flags);
        if (isel && !for_flags) return "R6";
        if (for_flags) begin
            if (op <= 5'd3 || op == 5'd18) return "R3";
            if (op <= 5'd7 || (op >= 5'd12 && op <= 5'd15)) return "R4";
            if (op == 5'd16 || op == 5'd17) return "R8";
            return "R11";
        end
        if (op == 5'd0 || op == 5'd2) return "R1";
        if (op == 5'd1 || op == 5'd3) return "R2";
        if (op <= 5'd7 || op == 5'd18) return "R5";
        if (op <= 5'd11) return "R7";
        if (op <= 5'd13) return "R10";
        if (op <= 5'd15) return "R9";
        if (op <= 5'd17) return "R8";
        return "R11";
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check outputs, then flags after the edge.
    task automatic run_op(input logic v, input logic [4:0] op, input logic isel,
                          input logic [31:0] a, input logic [31:0] b, input logic [7:0] im,
                          input logic [31:0] exp_res, input logic exp_we, input logic [3:0] exp_fl,
                          input string rq_res, input string rq_fl);
        @(negedge clk);
        op_valid = v; op_class = op; imm_sel = isel;
        src_r = a; src_a = b; imm = im;
        #1;
        check(rq_res, "result", result, exp_res);
        check(rq_res, "wr_en", {31'd0, wr_en}, {31'd0, exp_we});
        @(posedge clk);
        #1;
        check(rq_fl, "flags", {28'd0, flag_c, flag_z, flag_v, flag_n}, {28'd0, exp_fl});
    endtask

    initial begin
        #(200_000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_class = '0; imm_sel = 1'b0;
        src_r = '0; src_a = '0; imm = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R13", "flags after reset", {28'd0, flag_c, flag_z, flag_v, flag_n}, 32'd0);
        check("R12", "wr_en idle", {31'd0, wr_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(1'b1, VECS[i].op, VECS[i].isel, VECS[i].a, VECS[i].b, VECS[i].imm,
                   VECS[i].res, VECS[i].we, VECS[i].fl,
                   tag_of(VECS[i].op, VECS[i].isel, 1'b0), tag_of(VECS[i].op, VECS[i].isel, 1'b1));
        end

        // R12: an add that would set carry and zero is not issued.
        run_op(1'b0, 5'd0, 1'b0, 32'hFFFFFFFF, 32'h1, 8'h0, 32'h0, 1'b0, 4'b1001, "R12", "R12");

        // R13: reset in mid-run clears the flags left by the table.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R13", "flags after mid-run reset", {28'd0, flag_c, flag_z, flag_v, flag_n}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: borrow clear, so 5 - 5 - 0 gives zero without borrow.
        run_op(1'b1, 5'd3, 1'b0, 32'h5, 32'h5, 8'h0, 32'h0, 1'b1, 4'b0100, "R2", "R2");
        // R2: set carry with 0 - 1, then add-with-carry wraps to zero.
        run_op(1'b1, 5'd2, 1'b0, 32'h0, 32'h1, 8'h0, 32'hFFFFFFFF, 1'b1, 4'b1001, "R3", "R3");
        run_op(1'b1, 5'd1, 1'b0, 32'hFFFFFFFF, 32'h0, 8'h0, 32'h0, 1'b1, 4'b1100, "R2", "R2");
        // R11: unassigned class 20 keeps flags and does not write.
        run_op(1'b1, 5'd20, 1'b0, 32'h1, 32'h2, 8'h0, 32'h0, 1'b0, 4'b1100, "R11", "R11");
        // R6: the immediate 0x80 is unsigned, so 0 + 0x80 is positive.
        run_op(1'b1, 5'd0, 1'b1, 32'h0, 32'hFFFFFFFF, 8'h80, 32'h00000080, 1'b1, 4'b0000, "R6", "R6");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule